// File: doc/BRIEF.md
# Two-Wire Serial Register Access Port

This block is a synchronous slave port. It gives an external host access to an internal register file over three wires: a serial clock, one bidirectional data line and a select pin that marks each byte as a command byte or a data byte. When select is high, the host clocks in a control byte. That byte holds a register address and a transfer direction. When select is low, the host clocks whole data bytes into the chosen register or out of it. The port samples all host signals in the system clock domain.

The register file sits outside the block. On a write, the port raises a one-cycle strobe that carries the address and the byte. On a read, the port presents the address and loads the byte the register file returns. One address is a receive buffer that streams bytes. Each byte consumed from it raises a one-cycle pop strobe, which the buffer uses to advance its read pointer.

Bytes cut short by a change of select are discarded. Raising select during a read aborts the byte. After an abort, a buffer read resumes at the next byte, and a read of any other register starts again from the first bit of the same register.

Top module: `sreg_port`

## Requirements
- R1: While select is high, the port clocks in every eight rising serial clock edges as a control byte, MSB first. Bits 7..4 are the register address. Bit 3 is the direction, where 1 means read and 0 means write. Bits 2..0 are ignored.
- R2: After reset, the port is in write mode at address 0. Output enable is low and neither strobe is active. A data byte sent with no control byte therefore writes address 0.
- R3: If select changes after fewer than eight clock periods, those bits are discarded. This holds for control bytes and data bytes, and the next byte starts fresh.
- R4: In write mode with select low, the port samples data on rising serial clock edges, MSB first. Every eighth bit raises one single-cycle write strobe that carries the current address and the byte.
- R5: In read mode with select low, the port drives the byte MSB first. A new bit appears after each falling serial clock edge and holds across the following rising edge.
- R6: Output enable is high only in read mode while select is low. It drops combinationally when the select pin rises, and it drops when reset is asserted.
- R7: When select rises during a read, the bit counter clears. A register other than the buffer is then read again from its bit 7.
- R8: The receive buffer sits at address 12 by default. Each completed byte read from it raises a one-cycle pop strobe. An abort after at least one bit has been driven also pops, so the next read starts at the next byte. An abort before any bit has been driven does not pop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Host serial clock, idle high |
| sel_i | input | 1 | Command/data select: high selects control bytes |
| sdio_i | input | 1 | Data line input value |
| sdio_o | output | 1 | Data line output value |
| sdio_oe | output | 1 | Data line output enable |
| rd_addr | output | ADDR_W | Address presented to the register file |
| rd_data | input | DATA_W | Read data from the register file at rd_addr |
| wr_stb | output | 1 | One-cycle write strobe |
| wr_addr | output | ADDR_W | Write address, valid with wr_stb |
| wr_data | output | DATA_W | Write data, valid with wr_stb |
| pop_stb | output | 1 | One-cycle advance pulse for the receive buffer |

## Verification
The hardest case to reach is a receive-buffer abort. Select has to rise while the host is part way through a buffer byte, and the bench has to tell that case apart from an abort that lands exactly on a byte boundary. The stimulus first reads a complete buffer byte. It then reads four bits of the next byte, raises select and reads again, expecting the byte after the cut one. Next it aborts with no bits shifted and reads once more, expecting no byte to be skipped. The pop count and the bytes returned show which path the port took.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

  // direction flag carried in the control byte
  typedef enum logic {
    DIR_WR = 1'b0,
    DIR_RD = 1'b1
  } dir_e;

endpackage

// File: rtl/sreg_sync.sv
// Two-flop synchronizer per bit with a per-bit reset value
module sreg_sync #(
  parameter int             W       = 1,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [1:0] st_q;
    logic [1:0] st_d;

    always_comb begin
      st_d = {st_q[0], d[i]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= {2{RST_VAL[i]}};
      else        st_q <= st_d;
    end

    assign q[i] = st_q[1];
  end

endmodule

// File: rtl/sreg_bitcnt.sv
// Bit counter shared by control, write and read transfers
module sreg_bitcnt #(
  parameter int BITS = 8,
  localparam int CW  = $clog2(BITS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,      // select edge: discard partial byte
  input  logic          rx_step,  // sampling edge in control/write mode
  input  logic          tx_step,  // driving edge in read mode
  input  logic          tx_end,   // sampling edge in read mode
  output logic [CW-1:0] cnt,
  output logic          rx_done,
  output logic          tx_done
);

  localparam logic [CW-1:0] LAST = CW'(BITS - 1);
  localparam logic [CW-1:0] FULL = CW'(BITS);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d   = cnt_q;
    rx_done = 1'b0;
    tx_done = 1'b0;
    if (clr) begin
      cnt_d = '0;
    end else if (rx_step) begin
      if (cnt_q == LAST) begin
        cnt_d   = '0;
        rx_done = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else if (tx_step) begin
      if (cnt_q < FULL) cnt_d = cnt_q + 1'b1;
    end else if (tx_end && (cnt_q == FULL)) begin
      cnt_d   = '0;
      tx_done = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  assert_cnt_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL);

endmodule

// File: rtl/sreg_decode.sv
// Receive shifter, control byte decode, write and pop strobes
module sreg_decode
  import sreg_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 4,
  parameter int BUF_ADDR = 12,
  parameter int CW       = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              din,
  input  logic              rx_step,
  input  logic              rx_done,
  input  logic              ctl_mode,
  input  logic              abort,
  input  logic              tx_done,
  input  logic [CW-1:0]     cnt,
  output logic [ADDR_W-1:0] addr,
  output logic              rd_mode,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              pop_stb
);

  localparam int               DIR_POS = DATA_W - 1 - ADDR_W;
  localparam logic [ADDR_W-1:0] BUF    = ADDR_W'(BUF_ADDR);

  logic [DATA_W-2:0] rx_sh_q, rx_sh_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              rd_q, rd_d;
  logic              wr_stb_q, wr_stb_d;
  logic [ADDR_W-1:0] wr_addr_q, wr_addr_d;
  logic [DATA_W-1:0] wr_data_q, wr_data_d;
  logic              pop_q, pop_d;
  logic [DATA_W-1:0] byte_w;
  logic              is_buf;

  assign byte_w = {rx_sh_q, din};
  assign is_buf = (addr_q == BUF);

  always_comb begin
    rx_sh_d   = rx_step ? byte_w[DATA_W-2:0] : rx_sh_q;
    addr_d    = addr_q;
    rd_d      = rd_q;
    wr_stb_d  = 1'b0;
    wr_addr_d = wr_addr_q;
    wr_data_d = wr_data_q;
    if (rx_done) begin
      if (ctl_mode) begin
        addr_d = byte_w[DATA_W-1 -: ADDR_W];
        rd_d   = (dir_e'(byte_w[DIR_POS]) == DIR_RD);
      end else if (!rd_q) begin
        wr_stb_d  = 1'b1;
        wr_addr_d = addr_q;
        wr_data_d = byte_w;
      end
    end
    pop_d = is_buf && rd_q && (tx_done || (abort && (cnt != '0)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sh_q   <= '0;
      addr_q    <= '0;
      rd_q      <= 1'b0;
      wr_stb_q  <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
      pop_q     <= 1'b0;
    end else begin
      rx_sh_q   <= rx_sh_d;
      addr_q    <= addr_d;
      rd_q      <= rd_d;
      wr_stb_q  <= wr_stb_d;
      wr_addr_q <= wr_addr_d;
      wr_data_q <= wr_data_d;
      pop_q     <= pop_d;
    end
  end

  assign addr    = addr_q;
  assign rd_mode = rd_q;
  assign wr_stb  = wr_stb_q;
  assign wr_addr = wr_addr_q;
  assign wr_data = wr_data_q;
  assign pop_stb = pop_q;

  assert_wr_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_q |=> !wr_stb_q);

  assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_stb_q && pop_q));

  assert_pop_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pop_q |-> (addr_q == BUF));

endmodule

// File: rtl/sreg_txshift.sv
// Parallel-load, MSB-first output shifter
module sreg_txshift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [DATA_W-1:0] par,
  output logic              ser
);

  logic [DATA_W-2:0] sh_q, sh_d;
  logic              bit_q, bit_d;

  always_comb begin
    sh_d  = sh_q;
    bit_d = bit_q;
    if (load) begin
      bit_d = par[DATA_W-1];
      sh_d  = par[DATA_W-2:0];
    end else if (step) begin
      bit_d = sh_q[DATA_W-2];
      sh_d  = sh_q << 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      bit_q <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      bit_q <= bit_d;
    end
  end

  assign ser = bit_q;

endmodule

// File: rtl/sreg_port.sv
// Two-wire serial register access port, top level
module sreg_port #(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 4,
  parameter int BUF_ADDR = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_i,
  input  logic              sel_i,
  input  logic              sdio_i,
  output logic              sdio_o,
  output logic              sdio_oe,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              pop_stb
);

  localparam int CW = $clog2(DATA_W + 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q, rs_d;
  logic       rst_s_n;

  always_comb rs_d = {rs_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= rs_d;
  end

  assign rst_s_n = rs_q[1];

  // host inputs into the clock domain: {sck, sel, data}
  logic [2:0] pin_s;

  sreg_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk   (clk),
    .rst_n (rst_s_n),
    .d     ({sck_i, sel_i, sdio_i}),
    .q     (pin_s)
  );

  logic sck_s, sel_s, din_s;
  assign {sck_s, sel_s, din_s} = pin_s;

  // edge detection on the synchronized clock and select
  logic [1:0] prev_q, prev_d;

  always_comb prev_d = {sck_s, sel_s};

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) prev_q <= 2'b10;
    else          prev_q <= prev_d;
  end

  logic sck_rise, sck_fall, sel_rise, sel_fall;
  assign sck_rise =  sck_s & ~prev_q[1];
  assign sck_fall = ~sck_s &  prev_q[1];
  assign sel_rise =  sel_s & ~prev_q[0];
  assign sel_fall = ~sel_s &  prev_q[0];

  // mode qualified edges
  logic rd_mode;
  logic rd_active;
  logic rx_step, tx_step, tx_end, clr;

  assign rd_active = rd_mode & ~sel_s;
  assign rx_step   = sck_rise & ~rd_active;
  assign tx_step   = sck_fall &  rd_active;
  assign tx_end    = sck_rise &  rd_active;
  assign clr       = sel_rise | sel_fall;

  logic [CW-1:0] cnt;
  logic          rx_done, tx_done;

  sreg_bitcnt #(.BITS(DATA_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .clr     (clr),
    .rx_step (rx_step),
    .tx_step (tx_step),
    .tx_end  (tx_end),
    .cnt     (cnt),
    .rx_done (rx_done),
    .tx_done (tx_done)
  );

  logic [ADDR_W-1:0] addr;

  sreg_decode #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .BUF_ADDR (BUF_ADDR),
    .CW       (CW)
  ) u_dec (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .din      (din_s),
    .rx_step  (rx_step),
    .rx_done  (rx_done),
    .ctl_mode (sel_s),
    .abort    (sel_rise),
    .tx_done  (tx_done),
    .cnt      (cnt),
    .addr     (addr),
    .rd_mode  (rd_mode),
    .wr_stb   (wr_stb),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .pop_stb  (pop_stb)
  );

  sreg_txshift #(.DATA_W(DATA_W)) u_tx (
    .clk   (clk),
    .rst_n (rst_s_n),
    .load  (tx_step && (cnt == '0)),
    .step  (tx_step),
    .par   (rd_data),
    .ser   (sdio_o)
  );

  assign rd_addr = addr;
  assign sdio_oe = rd_mode & ~sel_s & ~sel_i;

  assert_abort_clear_R7: assert property (@(posedge clk) disable iff (!rst_s_n)
    sel_rise |=> (cnt == '0));

  assert_hold_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_s_n)
    sck_rise |=> $stable(sdio_o));

endmodule

// File: tb/test_sreg_port.sv
`timescale 1ns/1ps
module test_sreg_port;

  localparam int DW   = 8;
  localparam int AW   = 4;
  localparam int BUFA = 12;
  localparam int HALF = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sck_i = 1'b1;
  logic          sel_i = 1'b0;
  logic          sdio_i = 1'b0;
  logic          sdio_o, sdio_oe;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data;
  logic          wr_stb;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic          pop_stb;

  always #2.5 clk = ~clk;

  sreg_port #(.DATA_W(DW), .ADDR_W(AW), .BUF_ADDR(BUFA)) i_sreg_port (
    .clk(clk), .rst_n(rst_n), .sck_i(sck_i), .sel_i(sel_i), .sdio_i(sdio_i),
    .sdio_o(sdio_o), .sdio_oe(sdio_oe), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data), .pop_stb(pop_stb)
  );

  // register file and receive buffer model
  logic [DW-1:0] regs [16];
  logic [DW-1:0] fifo [16];
  logic [3:0]    ptr;
  int            wr_cnt, pop_cnt;
  logic [AW-1:0] last_wa;
  logic [DW-1:0] last_wd;

  assign rd_data = (rd_addr == AW'(BUFA)) ? fifo[ptr] : regs[rd_addr];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) begin
        regs[i] <= '0;
        fifo[i] <= DW'(8'h11 * (i + 1));
      end
      ptr     <= '0;
      wr_cnt  <= 0;
      pop_cnt <= 0;
      last_wa <= '0;
      last_wd <= '0;
    end else begin
      if (wr_stb) begin
        regs[wr_addr] <= wr_data;
        wr_cnt  <= wr_cnt + 1;
        last_wa <= wr_addr;
        last_wd <= wr_data;
      end
      if (pop_stb) begin
        ptr     <= ptr + 1'b1;
        pop_cnt <= pop_cnt + 1;
      end
    end
  end

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;
  bit oe_seen;

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    sck_i  = 1'b0;
    sdio_i = b;
    wait_clk(HALF);
    sck_i = 1'b1;
    wait_clk(HALF);
  endtask

  task automatic ctrl(input logic [3:0] a, input logic rd, input logic [2:0] dc);
    logic [7:0] w;
    w = {a, rd, dc};
    sel_i = 1'b1;
    wait_clk(4);
    for (int i = 7; i >= 0; i--) send_bit(w[i]);
    wait_clk(4);
    sel_i = 1'b0;
    wait_clk(6);
  endtask

  task automatic wbyte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    wait_clk(4);
  endtask

  task automatic rbits(input int n, output logic [7:0] v);
    v = '0;
    oe_seen = 1'b1;
    for (int i = 0; i < n; i++) begin
      sck_i = 1'b0;
      wait_clk(HALF);
      v = {v[6:0], sdio_o};
      if (!sdio_oe) oe_seen = 1'b0;
      sck_i = 1'b1;
      wait_clk(HALF);
    end
  endtask

  task automatic abort_read(input string req);
    sel_i = 1'b1;
    #1;
    chk(req, sdio_oe, 1'b0);
    wait_clk(6);
    sel_i = 1'b0;
    wait_clk(6);
  endtask

  task automatic t_reset;
    chk("R2 oe", sdio_oe, 1'b0);
    chk("R2 addr", rd_addr, 4'h0);
    chk("R2 wr_stb", wr_stb, 1'b0);
    chk("R2 pop_stb", pop_stb, 1'b0);
  endtask

  task automatic t_default_write;
    wbyte(8'hA5);
    chk("R2 count", wr_cnt, 1);
    chk("R2 addr0", last_wa, 4'h0);
    chk("R4 data", last_wd, 8'hA5);
    chk("R6 oe in write", sdio_oe, 1'b0);
  endtask

  task automatic t_ctrl_write;
    ctrl(4'h5, 1'b0, 3'b011);
    chk("R1 addr", rd_addr, 4'h5);
    wbyte(8'h3C);
    chk("R4 first", last_wd, 8'h3C);
    chk("R1 waddr", last_wa, 4'h5);
    wbyte(8'h81);
    chk("R4 count", wr_cnt, 3);
    chk("R4 second", last_wd, 8'h81);
  endtask

  task automatic t_partial;
    sel_i = 1'b1;
    wait_clk(4);
    for (int i = 0; i < 5; i++) send_bit(i[0]);
    sel_i = 1'b0;
    wait_clk(6);
    chk("R3 ctl kept", rd_addr, 4'h5);
    wbyte(8'h77);
    chk("R3 addr", last_wa, 4'h5);
    chk("R3 data", last_wd, 8'h77);
    for (int i = 0; i < 3; i++) send_bit(1'b1);
    sel_i = 1'b1;
    wait_clk(6);
    sel_i = 1'b0;
    wait_clk(6);
    chk("R3 no partial strobe", wr_cnt, 4);
    wbyte(8'h12);
    chk("R3 count", wr_cnt, 5);
    chk("R3 fresh byte", last_wd, 8'h12);
  endtask

  task automatic t_read_reg;
    logic [7:0] v;
    wbyte(8'h81);
    ctrl(4'h5, 1'b1, 3'b101);
    chk("R1 read addr", rd_addr, 4'h5);
    rbits(8, v);
    chk("R5 byte", v, 8'h81);
    chk("R6 oe during read", oe_seen, 1'b1);
    rbits(8, v);
    chk("R5 repeat", v, 8'h81);
    chk("R8 no pop", pop_cnt, 0);
  endtask

  task automatic t_abort_reg;
    logic [7:0] v;
    rbits(3, v);
    chk("R5 partial", v, 8'h04);
    abort_read("R6 oe release");
    rbits(8, v);
    chk("R7 restart", v, 8'h81);
    chk("R7 no pop", pop_cnt, 0);
  endtask

  task automatic t_buffer;
    logic [7:0] v;
    ctrl(4'(BUFA), 1'b1, 3'b000);
    rbits(8, v);
    chk("R8 first", v, 8'h11);
    chk("R8 pop1", pop_cnt, 1);
    rbits(4, v);
    chk("R8 partial", v, 8'h02);
    abort_read("R6 oe release buf");
    chk("R8 abort pop", pop_cnt, 2);
    rbits(8, v);
    chk("R8 resume next", v, 8'h33);
    chk("R8 pop3", pop_cnt, 3);
    abort_read("R6 oe release edge");
    chk("R8 boundary no pop", pop_cnt, 3);
    rbits(8, v);
    chk("R8 no skip", v, 8'h44);
  endtask

  task automatic t_back_to_write;
    ctrl(4'h3, 1'b0, 3'b111);
    chk("R6 oe write", sdio_oe, 1'b0);
    wbyte(8'hC3);
    chk("R1 addr3", last_wa, 4'h3);
    chk("R4 data c3", last_wd, 8'hC3);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(6);
    t_reset();
    t_default_write();
    t_ctrl_write();
    t_partial();
    t_read_reg();
    t_abort_reg();
    t_buffer();
    t_back_to_write();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

endmodule